// File: doc/BRIEF.md
# Backplane Configuration Register Responder

This block is the slave side of the configuration space of a modular instrument card. A simple register bus reaches two word offsets. Offset 0x00 serves as the identification word on a read. Its value depends on a strap that gives the addressing mode of the card. A write to offset 0x00 loads a logical address into a hidden register. That load happens only while the system holds the dynamic-configuration enable high. The logical address drives an output port, but a read can never return it.

Offset 0x02 returns a device-type word. The word carries a memory-size code in its top nibble, a fixed code in its middle byte and the board revision strap in its low nibble. The memory-size code comes from the requests of two optional plug-in module sites. An empty site drives 0, which means it needs no memory. A smaller non-zero code asks for more memory, so the block reports the smallest non-zero request it sees.

Top module: `reg_responder`

## Requirements
- R1: After reset, `bus_rdata` is 0x0000 and `log_addr` is 0xFF.
- R2: A read of offset 0x00 with `strap_a32` = 1 returns 0xDFF5 on `bus_rdata` one clock edge after the strobe.
- R3: A read of offset 0x00 with `strap_a32` = 0 returns 0xCFF5 on `bus_rdata` one clock edge after the strobe.
- R4: A write to offset 0x00 with `cfg_en` = 1 loads `bus_wdata[7:0]` into `log_addr` on the strobe edge.
- R5: A write to offset 0x00 with `cfg_en` = 0 leaves `log_addr` unchanged.
- R6: A read of offset 0x00 always returns the identification word and never the logical address.
- R7: A read of offset 0x02 returns {memory code, 0x21, `rev_strap`}, with the memory code in bits 15:12, 0x21 in bits 11:4 and the revision in bits 3:0.
- R8: When both module codes are non-zero, the memory code is the smaller of the two.
- R9: When exactly one module code is non-zero, the memory code is that code. When both are 0, the memory code is 0.
- R10: A write to offset 0x02 changes neither `log_addr` nor the value that offset 0x02 later reads.
- R11: A read of any other offset returns 0xFFFF.
- R12: `bus_rdata` holds its value on every cycle without a read strobe.
- R13: A change of a module code or of a strap shows in the very next read, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 16 | Write data |
| cfg_en | input | 1 | Dynamic-configuration enable |
| strap_a32 | input | 1 | 1 = 32-bit addressing, 0 = 24-bit addressing |
| mod_a_code | input | 4 | Memory request of module site A (0 = absent) |
| mod_b_code | input | 4 | Memory request of module site B (0 = absent) |
| rev_strap | input | 4 | Board revision |
| bus_rdata | output | 16 | Registered read data |
| log_addr | output | 8 | Latched logical address |

## Verification
Read data is registered once. A read strobe applied before a rising edge therefore shows its word on `bus_rdata` just after that edge. The bench drives the strobe on a falling edge and samples one falling edge later. `log_addr` also changes at the strobe edge, and the bench samples it at the same falling edge. The strap and module-code inputs feed the read path combinationally. The R13 checks change an input and read on the very next strobe, expecting the new value with no extra cycle.

// File: rtl/regs_pkg.sv
package regs_pkg;
    localparam int DATA_W = 16;
    localparam int LA_W   = 8;
    localparam int CODE_W = 4;

    localparam logic [DATA_W-1:0] ID_WORD_A32 = 16'hDFF5;
    localparam logic [DATA_W-1:0] ID_WORD_A24 = 16'hCFF5;
    localparam logic [7:0]        DEV_FIXED   = 8'h21;
    localparam logic [DATA_W-1:0] UNMAPPED    = 16'hFFFF;
    localparam logic [LA_W-1:0]   LA_RESET    = 8'hFF;

    typedef enum logic [1:0] {
        SPACE_ID   = 2'd0,
        SPACE_DEV  = 2'd1,
        SPACE_NONE = 2'd2
    } space_e;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic [LA_W-1:0]   la;
    } resp_state_t;
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
    import regs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output space_e            space
);
    localparam logic [ADDR_W-1:0] OFF_ID  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_DEV = ADDR_W'(2);

    always_comb begin
        if (addr == OFF_ID)       space = SPACE_ID;
        else if (addr == OFF_DEV) space = SPACE_DEV;
        else                      space = SPACE_NONE;
    end
endmodule

// File: rtl/mem_code_merge.sv
module mem_code_merge #(
    parameter int NUM_SITES = 2,
    parameter int CODE_W    = 4
) (
    input  logic [NUM_SITES*CODE_W-1:0] site_codes,
    output logic [CODE_W-1:0]           merged
);
    logic [CODE_W-1:0] cand;

    // Smallest non-zero request wins; all-zero gives zero.
    always_comb begin
        merged = '0;
        cand   = '0;
        for (int i = 0; i < NUM_SITES; i++) begin
            cand = site_codes[i*CODE_W +: CODE_W];
            if (cand != '0 && (merged == '0 || cand < merged))
                merged = cand;
        end
    end
endmodule

// File: rtl/read_word_sel.sv
module read_word_sel
    import regs_pkg::*;
(
    input  space_e              space,
    input  logic                a32,
    input  logic [CODE_W-1:0]   mem_code,
    input  logic [CODE_W-1:0]   rev,
    output logic [DATA_W-1:0]   word
);
    always_comb begin
        unique case (space)
            SPACE_ID:  word = a32 ? ID_WORD_A32 : ID_WORD_A24;
            SPACE_DEV: word = {mem_code, DEV_FIXED, rev};
            default:   word = UNMAPPED;
        endcase
    end
endmodule

// File: rtl/reg_responder.sv
module reg_responder
    import regs_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_SITES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              cfg_en,
    input  logic              strap_a32,
    input  logic [3:0]        mod_a_code,
    input  logic [3:0]        mod_b_code,
    input  logic [3:0]        rev_strap,
    output logic [15:0]       bus_rdata,
    output logic [7:0]        log_addr
);
    space_e            space;
    logic [CODE_W-1:0] mem_code;
    logic [DATA_W-1:0] rd_word;
    resp_state_t       st_d, st_q;

    cfg_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (bus_addr),
        .space (space)
    );

    mem_code_merge #(.NUM_SITES(NUM_SITES), .CODE_W(CODE_W)) u_merge (
        .site_codes ({mod_b_code, mod_a_code}),
        .merged     (mem_code)
    );

    read_word_sel u_rsel (
        .space    (space),
        .a32      (strap_a32),
        .mem_code (mem_code),
        .rev      (rev_strap),
        .word     (rd_word)
    );

    always_comb begin
        st_d = st_q;
        if (bus_sel && !bus_wr)
            st_d.rdata = rd_word;
        if (bus_sel && bus_wr && cfg_en && space == SPACE_ID)
            st_d.la = bus_wdata[LA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rdata <= '0;
            st_q.la    <= LA_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign log_addr  = st_q.la;
endmodule

// File: rtl/reg_responder_chk.sv
module reg_responder_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              cfg_en,
    input logic              strap_a32,
    input logic [15:0]       bus_rdata,
    input logic [7:0]        log_addr
);
    logic la_load;
    assign la_load = bus_sel && bus_wr && cfg_en && bus_addr == '0;

    assert_id_a32_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_wr && bus_addr == '0 && strap_a32 |=> bus_rdata == 16'hDFF5);

    assert_id_a24_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_wr && bus_addr == '0 && !strap_a32 |=> bus_rdata == 16'hCFF5);

    assert_la_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        la_load |=> log_addr == $past(bus_wdata[7:0]));

    assert_la_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !la_load |=> $stable(log_addr));

    assert_dev_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_wr && bus_addr == ADDR_W'(2) |=> bus_rdata[11:4] == 8'h21);

    assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_wr && bus_addr != '0 && bus_addr != ADDR_W'(2)
        |=> bus_rdata == 16'hFFFF);

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

bind reg_responder reg_responder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cfg_en    (cfg_en),
    .strap_a32 (strap_a32),
    .bus_rdata (bus_rdata),
    .log_addr  (log_addr)
);

// File: tb/tb_reg_responder.sv
module tb_reg_responder;
    localparam int ADDR_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic              cfg_en = 1'b0;
    logic              strap_a32 = 1'b1;
    logic [3:0]        mod_a_code = '0;
    logic [3:0]        mod_b_code = '0;
    logic [3:0]        rev_strap = 4'h3;
    logic [15:0]       bus_rdata;
    logic [7:0]        log_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    reg_responder #(.ADDR_W(ADDR_W), .NUM_SITES(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cfg_en(cfg_en),
        .strap_a32(strap_a32), .mod_a_code(mod_a_code), .mod_b_code(mod_b_code),
        .rev_strap(rev_strap), .bus_rdata(bus_rdata), .log_addr(log_addr)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // Strobe on a falling edge; the registered result is sampled one falling edge later.
    task automatic rd(input logic [ADDR_W-1:0] a);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    function automatic logic [15:0] dev_word(input logic [3:0] m, input logic [3:0] r);
        return {m, 8'h21, r};
    endfunction

    task automatic t_reset();
        check("R1 rdata", bus_rdata, 16'h0000);
        check("R1 log_addr", {8'h00, log_addr}, 16'h00FF);
    endtask

    task automatic t_id();
        strap_a32 = 1'b1; rd('0);
        check("R2", bus_rdata, 16'hDFF5);
        strap_a32 = 1'b0; rd('0);
        check("R3", bus_rdata, 16'hCFF5);
        strap_a32 = 1'b1;
    endtask

    task automatic t_la();
        cfg_en = 1'b1; wr('0, 16'hBE5A);
        check("R4 load", {8'h00, log_addr}, 16'h005A);
        rd('0);
        check("R6 id not la", bus_rdata, 16'hDFF5);
        cfg_en = 1'b0; wr('0, 16'h0033);
        check("R5 gated", {8'h00, log_addr}, 16'h005A);
        cfg_en = 1'b1; wr('0, 16'h0011);
        check("R4 reload", {8'h00, log_addr}, 16'h0011);
        cfg_en = 1'b0;
    endtask

    task automatic t_dev();
        mod_a_code = 4'h6; mod_b_code = 4'h9; rev_strap = 4'hA; rd(6'd2);
        check("R7/R8 min a", bus_rdata, dev_word(4'h6, 4'hA));
        mod_a_code = 4'hC; mod_b_code = 4'h2; rd(6'd2);
        check("R8 min b", bus_rdata, dev_word(4'h2, 4'hA));
        mod_a_code = 4'h0; mod_b_code = 4'h7; rd(6'd2);
        check("R9 only b", bus_rdata, dev_word(4'h7, 4'hA));
        mod_a_code = 4'h5; mod_b_code = 4'h0; rd(6'd2);
        check("R9 only a", bus_rdata, dev_word(4'h5, 4'hA));
        mod_a_code = 4'h0; mod_b_code = 4'h0; rd(6'd2);
        check("R9 none", bus_rdata, dev_word(4'h0, 4'hA));
        mod_a_code = 4'h4; mod_b_code = 4'h4; rd(6'd2);
        check("R8 equal", bus_rdata, dev_word(4'h4, 4'hA));
    endtask

    task automatic t_dev_write();
        cfg_en = 1'b1; wr(6'd2, 16'h1234);
        check("R10 la untouched", {8'h00, log_addr}, 16'h0011);
        rd(6'd2);
        check("R10 dev unchanged", bus_rdata, dev_word(4'h4, 4'hA));
        cfg_en = 1'b0;
    endtask

    task automatic t_unmapped();
        rd(6'd1);  check("R11 off1", bus_rdata, 16'hFFFF);
        rd(6'd4);  check("R11 off4", bus_rdata, 16'hFFFF);
        rd(6'd63); check("R11 off63", bus_rdata, 16'hFFFF);
    endtask

    task automatic t_hold();
        rd(6'd2);
        mod_a_code = 4'h1; rev_strap = 4'h5;
        repeat (3) @(negedge clk);
        check("R12 hold idle", bus_rdata, dev_word(4'h4, 4'hA));
        cfg_en = 1'b1; wr('0, 16'h0077);
        check("R12 hold on write", bus_rdata, dev_word(4'h4, 4'hA));
        cfg_en = 1'b0;
    endtask

    task automatic t_no_latency();
        mod_a_code = 4'h8; mod_b_code = 4'h3; rev_strap = 4'h1; rd(6'd2);
        check("R13 pre", bus_rdata, dev_word(4'h3, 4'h1));
        mod_b_code = 4'h0; rd(6'd2);
        check("R13 site removed", bus_rdata, dev_word(4'h8, 4'h1));
        strap_a32 = 1'b0; rd('0);
        check("R13 strap", bus_rdata, 16'hCFF5);
        strap_a32 = 1'b1; rd('0);
        check("R13 strap back", bus_rdata, 16'hDFF5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_id();
        t_la();
        t_dev();
        t_dev_write();
        t_unmapped();
        t_hold();
        t_no_latency();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule